// File: doc/BRIEF.md
# Neighborhood Coherence Hazard Scoreboard

This block sits at the entry of a speculative event-prediction pipeline in a discrete-event particle simulator. Space is divided into a 32×32×32 grid of cells. Each event that wants to enter the predictor names the cell of the bead it moved. Prediction for that event would read stale state if another event still inside the predictor touches any cell that borders it. The scoreboard records the cell of every event in flight, one entry per predictor stage. It holds an arriving event back while any in-flight event lies within one cell of it on every axis. Cells at opposite faces of the grid count as adjacent.

The pipeline moves on a single advance strobe. On each advance every tracked event moves one stage. The event in the last stage leaves and commits. Because the stages keep draining while entry is held, every stall ends. A restart, raised when an out-of-order insertion forces the speculative work to be thrown away, empties the tracker at once. A free-running counter records how many cycles entry spent stalled.

Top module: `hzd_scoreboard`

## Requirements
- R1: After synchronous reset no event is tracked: stall_o and commit_o are 0 and stall_cnt_o is 0.
- R2: stall_o is 1 exactly when req_valid_i is 1, restart_i is 0, and some tracked event (other than one committing this cycle) has a cell whose x, y and z each differ from the request by 0, +1 or -1 modulo 32. So coordinate 0 and coordinate 31 are adjacent.
- R3: accept_o is 1 exactly when req_valid_i and adv_i are 1, restart_i is 0 and stall_o is 0. An accepted event enters the first stage at that clock edge.
- R4: Each cycle with adv_i at 1 moves every tracked event one stage. With the default 23 stages, an event accepted in cycle n commits in the cycle that holds its 23rd advance after n. commit_o is 1 in that cycle and 0 otherwise.
- R5: While adv_i is 0, tracking holds its contents and no event is accepted or committed.
- R6: The event that commits in a cycle is excluded from that cycle's neighborhood test. If adv_i is 0, so that nothing commits, the event in the last stage still blocks.
- R7: restart_i clears all tracking at the next edge. In a restart cycle stall_o, accept_o and commit_o are 0, and abandoned events never commit.
- R8: stall_cnt_o increments by one after every cycle in which stall_o is 1, and holds otherwise. It is cleared only by reset.
- R9: Entry stays blocked while any one of several distinct in-flight events is a neighbor. It is released only once the last of them commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Abandon all in-flight events and clear tracking |
| adv_i | input | 1 | Pipeline advance; last stage commits when high |
| req_valid_i | input | 1 | An event requests entry |
| req_x_i | input | 5 | Cell x coordinate of the requesting event |
| req_y_i | input | 5 | Cell y coordinate of the requesting event |
| req_z_i | input | 5 | Cell z coordinate of the requesting event |
| stall_o | output | 1 | Coherence hazard: entry held |
| accept_o | output | 1 | Requesting event enters this cycle |
| commit_o | output | 1 | An event leaves the last stage and commits |
| stall_cnt_o | output | 16 | Count of stalled cycles |

## Verification
The bench walks a table of cell pairs. Some pairs are neighbors across the 0/31 seam on one or more axes, and some lie two cells apart on a single axis. A design that compared without wrap-around, or accepted a distance of two, would report the wrong hazard on those pairs. Directed runs cover the following cases:
- Commit latency, where a stage off by one moves the commit pulse.
- The cycle in which the blocking event commits. A design that ignored the committing-event exclusion would stall one extra cycle there, and one that excluded it without checking the advance strobe would release early.
- Two distinct blockers, to catch release on the first one.
- A restart, to catch stale entries or a commit pulse from an abandoned event.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int unsigned CW = 5;

    typedef logic [CW-1:0] coord_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
        coord_t z;
    } cell_t;

    // one axis is near when the wrapped difference is -1, 0 or +1
    function automatic logic axis_near(input coord_t a, input coord_t b);
        coord_t d;
        d = a - b;
        return (d == CW'(0)) || (d == CW'(1)) || (d == {CW{1'b1}});
    endfunction

endpackage

// File: rtl/hzd_near_cmp.sv
module hzd_near_cmp
    import hzd_pkg::*;
(
    input  cell_t a_i,
    input  cell_t b_i,
    output logic  hit_o
);
    always_comb begin
        hit_o = axis_near(a_i.x, b_i.x)
              & axis_near(a_i.y, b_i.y)
              & axis_near(a_i.z, b_i.z);
    end
endmodule

// File: rtl/hzd_track_pipe.sv
module hzd_track_pipe
    import hzd_pkg::*;
#(
    parameter int unsigned DEPTH = 23
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               clr_i,
    input  logic               adv_i,
    input  logic               load_i,
    input  cell_t              load_cell_i,
    output logic [DEPTH-1:0]   vld_o,
    output cell_t [DEPTH-1:0]  cell_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            vld_o <= '0;
        end else if (adv_i) begin
            vld_o <= {vld_o[DEPTH-2:0], load_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cell_o <= '0;
        end else if (adv_i) begin
            cell_o[0] <= load_cell_i;
            for (int s = 1; s < int'(DEPTH); s++) begin
                cell_o[s] <= cell_o[s-1];
            end
        end
    end
endmodule

// File: rtl/hzd_stall_counter.sv
module hzd_stall_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/hzd_scoreboard.sv
module hzd_scoreboard
    import hzd_pkg::*;
#(
    parameter int unsigned DEPTH = 23,
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             restart_i,
    input  logic             adv_i,
    input  logic             req_valid_i,
    input  logic [CW-1:0]    req_x_i,
    input  logic [CW-1:0]    req_y_i,
    input  logic [CW-1:0]    req_z_i,
    output logic             stall_o,
    output logic             accept_o,
    output logic             commit_o,
    output logic [CNT_W-1:0] stall_cnt_o
);
    localparam logic [DEPTH-1:0] LAST_MASK = {1'b1, {(DEPTH-1){1'b0}}};

    cell_t              req_cell;
    logic [DEPTH-1:0]   vld;
    cell_t [DEPTH-1:0]  cells;
    logic [DEPTH-1:0]   hit;
    logic [DEPTH-1:0]   live;
    logic               conflict;

    assign req_cell = '{x: req_x_i, y: req_y_i, z: req_z_i};

    generate
        for (genvar s = 0; s < int'(DEPTH); s++) begin : g_cmp
            hzd_near_cmp u_cmp (
                .a_i   (cells[s]),
                .b_i   (req_cell),
                .hit_o (hit[s])
            );
        end
    endgenerate

    // the entry leaving on this advance no longer guards the neighborhood
    always_comb begin
        live     = vld & ~(adv_i ? LAST_MASK : '0);
        conflict = |(hit & live);
        stall_o  = req_valid_i & ~restart_i & conflict;
        accept_o = req_valid_i & adv_i & ~restart_i & ~conflict;
        commit_o = vld[DEPTH-1] & adv_i & ~restart_i;
    end

    hzd_track_pipe #(.DEPTH(DEPTH)) u_pipe (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .clr_i       (restart_i),
        .adv_i       (adv_i),
        .load_i      (accept_o),
        .load_cell_i (req_cell),
        .vld_o       (vld),
        .cell_o      (cells)
    );

    hzd_stall_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .inc_i (stall_o),
        .cnt_o (stall_cnt_o)
    );
endmodule

// File: rtl/hzd_scoreboard_chk.sv
module hzd_scoreboard_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             restart_i,
    input logic             adv_i,
    input logic             req_valid_i,
    input logic             stall_o,
    input logic             accept_o,
    input logic             commit_o,
    input logic [CNT_W-1:0] stall_cnt_o
);
    AST_RESET_EMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (stall_cnt_o == '0) && !commit_o && !stall_o); // R1

    AST_STALL_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_o |-> req_valid_i && !restart_i); // R2

    AST_ACCEPT_CLEAN: assert property (@(posedge clk_i) disable iff (rst_i)
        accept_o |-> adv_i && !stall_o && !restart_i); // R3

    AST_COMMIT_ON_ADV: assert property (@(posedge clk_i) disable iff (rst_i)
        commit_o |-> adv_i && !restart_i); // R4

    AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !adv_i |-> !accept_o && !commit_o); // R5

    AST_RESTART_EMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_i |=> !stall_o && !commit_o); // R7

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_o |=> stall_cnt_o == $past(stall_cnt_o) + 1'b1); // R8

    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !stall_o |=> $stable(stall_cnt_o)); // R8
endmodule

bind hzd_scoreboard hzd_scoreboard_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_hzd_scoreboard.sv
module tb_hzd_scoreboard;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       restart = 1'b0;
    logic       adv = 1'b0;
    logic       req_valid = 1'b0;
    logic [4:0] rx = '0, ry = '0, rz = '0;
    logic       stall, accept, commit;
    logic [15:0] scnt;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hzd_scoreboard dut (
        .clk_i(clk), .rst_i(rst), .restart_i(restart), .adv_i(adv),
        .req_valid_i(req_valid), .req_x_i(rx), .req_y_i(ry), .req_z_i(rz),
        .stall_o(stall), .accept_o(accept), .commit_o(commit),
        .stall_cnt_o(scnt)
    );

    // {ref x, ref y, ref z, probe x, probe y, probe z, expect hazard}
    localparam int NV = 12;
    localparam logic [30:0] VEC [NV] = '{
        {5'd5,  5'd5,  5'd5,  5'd5,  5'd5,  5'd5,  1'b1},
        {5'd5,  5'd5,  5'd5,  5'd6,  5'd4,  5'd5,  1'b1},
        {5'd5,  5'd5,  5'd5,  5'd7,  5'd5,  5'd5,  1'b0},
        {5'd0,  5'd0,  5'd0,  5'd31, 5'd31, 5'd31, 1'b1},
        {5'd0,  5'd0,  5'd0,  5'd30, 5'd0,  5'd0,  1'b0},
        {5'd31, 5'd10, 5'd20, 5'd0,  5'd9,  5'd21, 1'b1},
        {5'd16, 5'd16, 5'd16, 5'd16, 5'd16, 5'd18, 1'b0},
        {5'd16, 5'd16, 5'd16, 5'd15, 5'd17, 5'd15, 1'b1},
        {5'd1,  5'd31, 5'd0,  5'd0,  5'd0,  5'd31, 1'b1},
        {5'd3,  5'd3,  5'd3,  5'd3,  5'd5,  5'd3,  1'b0},
        {5'd10, 5'd10, 5'd10, 5'd10, 5'd10, 5'd9,  1'b1},
        {5'd29, 5'd2,  5'd2,  5'd31, 5'd2,  5'd2,  1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive at the falling edge, settle, then the caller samples
    task automatic step(input logic v, input logic [4:0] x, y, z,
                        input logic a, input logic rs);
        @(negedge clk);
        req_valid = v; rx = x; ry = y; rz = z; adv = a; restart = rs;
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int base;
        // R1 reset state
        repeat (3) @(negedge clk);
        step(1, 0, 0, 0, 0, 0);
        rst = 1'b0;
        step(1, 0, 0, 0, 0, 0);
        chk("R1 stall", int'(stall), 0);
        chk("R1 commit", int'(commit), 0);
        chk("R1 count", int'(scnt), 0);

        // R2/R5 neighborhood table, probes with the pipeline held
        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v = VEC[i];
            step(0, 0, 0, 0, 0, 1);
            step(1, v[30:26], v[25:21], v[20:16], 1, 0);
            chk("R3 accept on empty", int'(accept), 1);
            step(1, v[15:11], v[10:6], v[5:1], 0, 0);
            chk("R2 neighborhood", int'(stall), int'(v[0]));
            chk("R5 no entry while held", int'(accept), 0);
            step(1, v[15:11], v[10:6], v[5:1], 0, 0);
            chk("R5 tracking held", int'(stall), int'(v[0]));
        end

        // R4 commit latency
        step(0, 0, 0, 0, 0, 1);
        step(1, 8, 8, 8, 1, 0);
        chk("R3 accept", int'(accept), 1);
        for (int k = 1; k <= 22; k++) begin
            step(0, 0, 0, 0, 1, 0);
            chk("R4 no early commit", int'(commit), 0);
        end
        step(0, 0, 0, 0, 1, 0);
        chk("R4 commit after 23 advances", int'(commit), 1);
        step(0, 0, 0, 0, 1, 0);
        chk("R4 single commit pulse", int'(commit), 0);

        // R6/R8 stall, hold in last stage, release as blocker commits
        step(0, 0, 0, 0, 0, 1);
        step(1, 5, 5, 5, 1, 0);
        chk("R3 accept", int'(accept), 1);
        step(1, 6, 6, 6, 1, 0);
        base = int'(scnt);
        chk("R2 stall on neighbor", int'(stall), 1);
        for (int k = 2; k <= 22; k++) begin
            step(1, 6, 6, 6, 1, 0);
            chk("R2 stall persists", int'(stall), 1);
        end
        step(1, 6, 6, 6, 0, 0);
        chk("R6 last stage blocks without advance", int'(stall), 1);
        step(1, 6, 6, 6, 1, 0);
        chk("R6 committing event excluded", int'(stall), 0);
        chk("R6 accept with commit", int'(accept), 1);
        chk("R6 commit same cycle", int'(commit), 1);
        step(0, 0, 0, 0, 0, 0);
        chk("R8 stall count", int'(scnt) - base, 23);

        // R9 two distinct blockers
        step(0, 0, 0, 0, 0, 1);
        step(1, 4, 4, 4, 1, 0);
        chk("R3 accept A", int'(accept), 1);
        step(1, 6, 4, 4, 1, 0);
        chk("R2 distance two admitted", int'(accept), 1);
        for (int k = 2; k <= 23; k++) begin
            step(1, 5, 4, 4, 1, 0);
            chk("R9 stall while any neighbor", int'(stall), 1);
        end
        step(1, 5, 4, 4, 1, 0);
        chk("R9 release after last blocker", int'(stall), 0);
        chk("R9 accept", int'(accept), 1);

        // R7 restart
        step(0, 0, 0, 0, 0, 1);
        step(1, 9, 9, 9, 1, 0);
        step(0, 0, 0, 0, 1, 0);
        step(1, 9, 9, 9, 1, 1);
        chk("R7 no stall in restart", int'(stall), 0);
        chk("R7 no accept in restart", int'(accept), 0);
        step(1, 9, 9, 9, 1, 0);
        chk("R7 cleared", int'(stall), 0);
        chk("R7 accept after restart", int'(accept), 1);
        for (int k = 1; k <= 22; k++) begin
            step(0, 0, 0, 0, 1, 0);
            chk("R7 abandoned never commit", int'(commit), 0);
        end
        step(0, 0, 0, 0, 1, 0);
        chk("R4 new event commits", int'(commit), 1);

        done = 1'b1;
        finish_run();
    end
endmodule